// File: doc/BRIEF.md
# Aligned Load/Store Address Unit

This unit sits between instruction decode and a simple 32-bit synchronous data memory. Each cycle it may receive one memory instruction: a six-bit operation code, a base register value, a register offset, a 16-bit immediate offset and the value of the register named in the destination field. It decodes the access size and direction. It adds the base to the selected offset and forces the sum to natural alignment for the access size. It then drives address, byte enables, write enable and write data onto the memory port in the same cycle.

Misaligned halfword and word addresses never fault. The low address bits are cleared, so the access rounds down to the enclosing aligned unit. Byte lanes are big-endian: the byte at address offset 0 sits in bits 31:24 of the memory word. The memory answers a read one cycle after the request. The unit then extracts the addressed byte, halfword or word from the returned word, zero-extends it, and presents it with a one-cycle completion pulse.

Top module: `lsu_addr_unit`

## Requirements
- R1: An access is issued (`mem_en` high) only when `req_valid` is high and the code is one of 0x30, 0x31, 0x32, 0x34, 0x35, 0x36, 0x38, 0x39, 0x3A, 0x3C, 0x3D or 0x3E. For any other code `mem_en`, `mem_we` and `mem_be` stay low and no load completes. Code bit 2 set means store. Code bit 3 set means immediate offset. Code bits 1:0 give the size: 0 is byte, 1 is halfword, 2 is word.
- R2: The effective address is `base_val` plus `reg_off` for register-offset codes, or plus `imm_off` sign-extended from 16 bits for immediate codes, modulo 2^32.
- R3: `mem_addr` is the effective address with bit 0 cleared for halfwords, bits 1:0 cleared for words, and unchanged for bytes. Misaligned accesses are rounded down and never raise a fault.
- R4: `mem_be` bit 3 selects data bits 31:24 (address offset 0) and bit 0 selects bits 7:0 (offset 3). A byte access drives 4'b1000 shifted right by address bits 1:0. A halfword access drives 4'b1100 at offset 0 and 4'b0011 at offset 2. A word access drives 4'b1111. With no access the value is 4'b0000.
- R5: On a store, `mem_wdata` carries `store_val[7:0]` in all four lanes for a byte, `store_val[15:0]` in both halves for a halfword, and `store_val` unchanged for a word.
- R6: `mem_we` is high exactly when an issued access is a store. Loads never assert it.
- R7: For each load issued in cycle k, `ld_done` is high in cycle k+1 only. `ld_result` then holds the addressed lane of `mem_rdata`, zero-extended to 32 bits. `ld_result` is zero whenever `ld_done` is low.
- R8: While `rst` is high and in the first cycle after it, `ld_done` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | An instruction is presented this cycle |
| opcode | input | 6 | Operation code of the instruction |
| base_val | input | 32 | Base register value |
| reg_off | input | 32 | Register offset value |
| imm_off | input | 16 | Immediate offset, sign-extended inside |
| store_val | input | 32 | Value of the destination-field register |
| mem_en | output | 1 | Memory access strobe |
| mem_we | output | 1 | Memory write enable |
| mem_addr | output | 32 | Aligned byte address |
| mem_be | output | 4 | Byte-lane enables, bit 3 = bits 31:24 |
| mem_wdata | output | 32 | Lane-replicated store data |
| mem_rdata | input | 32 | Read word, valid the cycle after a read |
| ld_done | output | 1 | Load result valid pulse |
| ld_result | output | 32 | Zero-extended load data |

## Verification
The memory-port results (`mem_en`, `mem_we`, `mem_addr`, `mem_be`, `mem_wdata`) are combinational from the request. The driver checks them one nanosecond after it drives the inputs, inside the same cycle. A load result is due exactly one clock after its request cycle. The driver files each expected load with that due cycle number. The monitor samples two nanoseconds after each rising edge and flags a result that arrives early, late, unexpectedly or with the wrong value. Expected load data comes from a shadow memory that the driver updates with its own lane arithmetic for every store. Back-to-back stores and loads therefore check the ordering between them.

// File: rtl/lsu_pkg.sv
package lsu_pkg;

    localparam int XLEN  = 32;
    localparam int LANES = XLEN / 8;
    localparam int OFFW  = $clog2(LANES);
    localparam int SHW   = $clog2(XLEN);

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2,
        SZ_NONE = 2'd3
    } acc_size_e;

    typedef struct packed {
        logic      valid;
        logic      is_store;
        logic      use_imm;
        acc_size_e size;
    } acc_cmd_t;

    function automatic acc_cmd_t decode_op(input logic [5:0] op);
        acc_cmd_t c;
        c.valid    = (op[5:4] == 2'b11) && (op[1:0] != 2'b11);
        c.is_store = op[2];
        c.use_imm  = op[3];
        c.size     = acc_size_e'(op[1:0]);
        return c;
    endfunction

    function automatic logic [OFFW:0] size_bytes(input acc_size_e sz);
        case (sz)
            SZ_BYTE: return (OFFW+1)'(1);
            SZ_HALF: return (OFFW+1)'(2);
            default: return (OFFW+1)'(LANES);
        endcase
    endfunction

endpackage

// File: rtl/lsu_decode.sv
module lsu_decode
    import lsu_pkg::*;
(
    input  logic       req_valid,
    input  logic [5:0] opcode,
    output acc_cmd_t   cmd
);
    acc_cmd_t raw;

    always_comb begin
        raw       = decode_op(opcode);
        cmd       = raw;
        cmd.valid = raw.valid & req_valid;
    end
endmodule

// File: rtl/lsu_agen.sv
module lsu_agen
    import lsu_pkg::*;
#(
    parameter int IMM_W = 16
) (
    input  acc_cmd_t               cmd,
    input  logic [XLEN-1:0]        base_val,
    input  logic [XLEN-1:0]        reg_off,
    input  logic [IMM_W-1:0]       imm_off,
    output logic [XLEN-1:0]        addr,
    output logic [LANES-1:0]       be
);
    localparam int EXT_W = XLEN - IMM_W;

    logic [XLEN-1:0] offset;
    logic [XLEN-1:0] ea;
    logic [OFFW:0]   nbytes;
    logic [OFFW-1:0] lo;

    always_comb begin
        offset = cmd.use_imm ? {{EXT_W{imm_off[IMM_W-1]}}, imm_off} : reg_off;
        ea     = base_val + offset;
        nbytes = size_bytes(cmd.size);
        case (cmd.size)
            SZ_HALF: addr = {ea[XLEN-1:1], 1'b0};
            SZ_WORD: addr = {ea[XLEN-1:OFFW], {OFFW{1'b0}}};
            default: addr = ea;
        endcase
        lo = addr[OFFW-1:0];
        // lane i counts from the most significant byte (address offset 0)
        for (int i = 0; i < LANES; i++) begin
            be[LANES-1-i] = cmd.valid &&
                            (i >= int'(lo)) &&
                            (i <  int'(lo) + int'(nbytes));
        end
    end
endmodule

// File: rtl/lsu_wfmt.sv
module lsu_wfmt
    import lsu_pkg::*;
(
    input  acc_cmd_t          cmd,
    input  logic [XLEN-1:0]   store_val,
    output logic [XLEN-1:0]   wdata
);
    logic [XLEN-1:0] rep;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        always_comb begin
            case (cmd.size)
                SZ_BYTE: rep[8*g +: 8] = store_val[7:0];
                SZ_HALF: rep[8*g +: 8] = store_val[8*(g%2) +: 8];
                default: rep[8*g +: 8] = store_val[8*g +: 8];
            endcase
        end
    end

    assign wdata = (cmd.valid && cmd.is_store) ? rep : '0;
endmodule

// File: rtl/lsu_ldext.sv
module lsu_ldext
    import lsu_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  acc_cmd_t          cmd,
    input  logic [OFFW-1:0]   lane_lo,
    input  logic [XLEN-1:0]   rdata,
    output logic              done,
    output logic [XLEN-1:0]   result
);
    logic            pend;
    acc_size_e       pend_size;
    logic [OFFW-1:0] pend_lo;

    always_ff @(posedge clk) begin
        if (rst) begin
            pend      <= 1'b0;
            pend_size <= SZ_WORD;
            pend_lo   <= '0;
        end else begin
            pend <= cmd.valid & ~cmd.is_store;
            if (cmd.valid & ~cmd.is_store) begin
                pend_size <= cmd.size;
                pend_lo   <= lane_lo;
            end
        end
    end

    logic [OFFW:0]     nbytes;
    logic [OFFW:0]     tail;
    logic [SHW-1:0]    sh;
    logic [XLEN-1:0]   keep;

    always_comb begin
        nbytes = size_bytes(pend_size);
        tail   = (OFFW+1)'(LANES) - {1'b0, pend_lo} - nbytes;
        sh     = {tail[OFFW-1:0], 3'b000};
        for (int i = 0; i < LANES; i++) begin
            keep[8*i +: 8] = (i < int'(nbytes)) ? 8'hFF : 8'h00;
        end
        result = pend ? ((rdata >> sh) & keep) : '0;
    end

    assign done = pend;
endmodule

// File: rtl/lsu_addr_unit.sv
module lsu_addr_unit
    import lsu_pkg::*;
#(
    parameter int IMM_W = 16
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               req_valid,
    input  logic [5:0]         opcode,
    input  logic [31:0]        base_val,
    input  logic [31:0]        reg_off,
    input  logic [IMM_W-1:0]   imm_off,
    input  logic [31:0]        store_val,
    output logic               mem_en,
    output logic               mem_we,
    output logic [31:0]        mem_addr,
    output logic [3:0]         mem_be,
    output logic [31:0]        mem_wdata,
    input  logic [31:0]        mem_rdata,
    output logic               ld_done,
    output logic [31:0]        ld_result
);
    acc_cmd_t cmd;

    lsu_decode u_dec (
        .req_valid (req_valid),
        .opcode    (opcode),
        .cmd       (cmd)
    );

    lsu_agen #(.IMM_W(IMM_W)) u_agen (
        .cmd      (cmd),
        .base_val (base_val),
        .reg_off  (reg_off),
        .imm_off  (imm_off),
        .addr     (mem_addr),
        .be       (mem_be)
    );

    lsu_wfmt u_wfmt (
        .cmd       (cmd),
        .store_val (store_val),
        .wdata     (mem_wdata)
    );

    lsu_ldext u_ldext (
        .clk     (clk),
        .rst     (rst),
        .cmd     (cmd),
        .lane_lo (mem_addr[OFFW-1:0]),
        .rdata   (mem_rdata),
        .done    (ld_done),
        .result  (ld_result)
    );

    assign mem_en = cmd.valid;
    assign mem_we = cmd.valid & cmd.is_store;
endmodule

// File: rtl/lsu_addr_unit_checker.sv
module lsu_addr_unit_checker (
    input logic        clk,
    input logic        rst,
    input logic        mem_en,
    input logic        mem_we,
    input logic [31:0] mem_addr,
    input logic [3:0]  mem_be,
    input logic [31:0] mem_wdata,
    input logic        ld_done,
    input logic [31:0] ld_result
);
    assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (rst)
        !mem_en |-> (mem_be == 4'b0000 && !mem_we));

    assert_word_aligned_R3: assert property (@(posedge clk) disable iff (rst)
        (mem_en && mem_be == 4'b1111) |-> (mem_addr[1:0] == 2'b00));

    assert_half_aligned_R3: assert property (@(posedge clk) disable iff (rst)
        (mem_en && $countones(mem_be) == 2) |-> (mem_addr[0] == 1'b0));

    assert_be_shape_R4: assert property (@(posedge clk) disable iff (rst)
        mem_en |-> ($countones(mem_be) == 1 || $countones(mem_be) == 2 ||
                    $countones(mem_be) == 4));

    assert_byte_lane_R4: assert property (@(posedge clk) disable iff (rst)
        (mem_en && $countones(mem_be) == 1) |-> (mem_be == (4'b1000 >> mem_addr[1:0])));

    assert_byte_replicate_R5: assert property (@(posedge clk) disable iff (rst)
        (mem_we && $countones(mem_be) == 1) |->
        (mem_wdata[31:24] == mem_wdata[7:0] && mem_wdata[23:16] == mem_wdata[7:0] &&
         mem_wdata[15:8] == mem_wdata[7:0]));

    assert_done_follows_R7: assert property (@(posedge clk) disable iff (rst)
        (mem_en && !mem_we) |=> ld_done);

    assert_done_cause_R7: assert property (@(posedge clk) disable iff (rst)
        ld_done |-> $past(mem_en && !mem_we));

    assert_result_idle_R7: assert property (@(posedge clk) disable iff (rst)
        !ld_done |-> (ld_result == 32'h0));
endmodule

bind lsu_addr_unit lsu_addr_unit_checker u_chk (
    .clk       (clk),
    .rst       (rst),
    .mem_en    (mem_en),
    .mem_we    (mem_we),
    .mem_addr  (mem_addr),
    .mem_be    (mem_be),
    .mem_wdata (mem_wdata),
    .ld_done   (ld_done),
    .ld_result (ld_result)
);

// File: tb/tb_lsu_addr_unit.sv
`timescale 1ns/1ps
module tb_lsu_addr_unit;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic [5:0]  opcode = '0;
    logic [31:0] base_val = '0, reg_off = '0, store_val = '0;
    logic [15:0] imm_off = '0;
    logic        mem_en, mem_we, ld_done;
    logic [31:0] mem_addr, mem_wdata, ld_result;
    logic [3:0]  mem_be;
    logic [31:0] mem_rdata = '0;

    always #4 clk = ~clk;

    lsu_addr_unit dut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .opcode(opcode),
        .base_val(base_val), .reg_off(reg_off), .imm_off(imm_off),
        .store_val(store_val), .mem_en(mem_en), .mem_we(mem_we),
        .mem_addr(mem_addr), .mem_be(mem_be), .mem_wdata(mem_wdata),
        .mem_rdata(mem_rdata), .ld_done(ld_done), .ld_result(ld_result)
    );

    logic [31:0] mem     [0:63];
    logic [31:0] shadow  [0:63];
    int checks = 0, failures = 0, cyc = 0;
    int          due_q[$];
    logic [31:0] val_q[$];

    initial begin
        for (int i = 0; i < 64; i++) begin
            mem[i]    = 32'h1357_9BDF ^ (i * 32'h0103_0507);
            shadow[i] = mem[i];
        end
    end

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (mem_en) begin
            if (mem_we) begin
                for (int b = 0; b < 4; b++)
                    if (mem_be[b]) mem[mem_addr[7:2]][8*b +: 8] <= mem_wdata[8*b +: 8];
            end else begin
                mem_rdata <= mem[mem_addr[7:2]];
            end
        end
    end

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // monitor: load results are due one cycle after their request
    always @(posedge clk) begin
        #2;
        if (!rst) begin
            if (due_q.size() > 0 && due_q[0] < cyc) begin
                chk(1'b0, "R7 load done missing", 32'(cyc), 32'(due_q[0]));
                void'(due_q.pop_front());
                void'(val_q.pop_front());
            end
            if (ld_done) begin
                if (due_q.size() == 0 || due_q[0] != cyc) begin
                    chk(1'b0, "R1/R7 unexpected load done", 32'(cyc), 32'h0);
                end else begin
                    chk(ld_result == val_q[0], "R7 load result", ld_result, val_q[0]);
                    void'(due_q.pop_front());
                    void'(val_q.pop_front());
                end
            end else begin
                chk(ld_result == 32'h0, "R7 idle result zero", ld_result, 32'h0);
            end
        end
    end

    // driver: presents one instruction for one cycle, checks the port, files expectations
    task automatic issue(input logic [5:0] op, input logic [31:0] base, input logic [31:0] roff,
                         input logic [15:0] imm, input logic [31:0] sval);
        bit          legal, st;
        int          sz;
        logic [31:0] ea, ad, ew, word, lv;
        logic [3:0]  eb;
        @(negedge clk);
        req_valid = 1'b1; opcode = op; base_val = base; reg_off = roff;
        imm_off = imm; store_val = sval;
        #1;
        legal = (op[5:4] == 2'b11) && (op[1:0] != 2'b11);
        st    = op[2];
        sz    = op[1:0];
        ea    = base + (op[3] ? {{16{imm[15]}}, imm} : roff);
        ad    = (sz == 0) ? ea : (sz == 1) ? (ea & ~32'h1) : (ea & ~32'h3);
        eb    = !legal ? 4'b0000 : (sz == 0) ? (4'b1000 >> ad[1:0]) :
                (sz == 1) ? (ad[1] ? 4'b0011 : 4'b1100) : 4'b1111;
        ew    = (sz == 0) ? {4{sval[7:0]}} : (sz == 1) ? {2{sval[15:0]}} : sval;
        chk(mem_en == legal, "R1 mem_en", 32'(mem_en), 32'(legal));
        chk(mem_be == eb, "R4 byte enables", 32'(mem_be), 32'(eb));
        chk(mem_we == (legal && st), "R6 write enable", 32'(mem_we), 32'(legal && st));
        if (legal) begin
            chk(mem_addr == ad, "R2/R3 aligned address", mem_addr, ad);
            if (st) begin
                chk(mem_wdata == ew, "R5 store data", mem_wdata, ew);
                for (int b = 0; b < 4; b++)
                    if (eb[b]) shadow[ad[7:2]][8*b +: 8] = ew[8*b +: 8];
            end else begin
                word = shadow[ad[7:2]];
                if (sz == 0)      lv = {24'h0, word[8*(3-ad[1:0]) +: 8]};
                else if (sz == 1) lv = ad[1] ? {16'h0, word[15:0]} : {16'h0, word[31:16]};
                else              lv = word;
                due_q.push_back(cyc + 1);
                val_q.push_back(lv);
            end
        end
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            req_valid = 1'b0;
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk(ld_done == 1'b0, "R8 done low in reset", 32'(ld_done), 32'h0);
        rst = 1'b0;
        @(negedge clk);
        chk(ld_done == 1'b0, "R8 done low after reset", 32'(ld_done), 32'h0);
        chk(mem_en == 1'b0, "R1 idle after reset", 32'(mem_en), 32'h0);

        // R2 register-offset word loads and stores
        issue(6'h32, 32'h0000_0010, 32'h0000_0004, 16'h0, 32'h0);
        issue(6'h36, 32'h0000_0020, 32'h0000_0000, 16'h0, 32'hDEAD_BEEF);
        issue(6'h32, 32'h0000_0018, 32'h0000_0008, 16'h0, 32'h0);
        idle(2);
        // R4 byte stores in every lane, then byte loads in every lane
        for (int k = 0; k < 4; k++)
            issue(6'h34, 32'h0000_0040, 32'(k), 16'h0, 32'hA0 + 32'(k));
        for (int k = 0; k < 4; k++)
            issue(6'h30, 32'h0000_0040, 32'(k), 16'h0, 32'h0);
        idle(2);
        // R3 misaligned halfword and word accesses round down
        issue(6'h35, 32'h0000_0051, 32'h0, 16'h0, 32'h1234_8765);
        issue(6'h35, 32'h0000_0053, 32'h0, 16'h0, 32'h0000_C0DE);
        issue(6'h31, 32'h0000_0050, 32'h1, 16'h0, 32'h0);
        issue(6'h31, 32'h0000_0050, 32'h3, 16'h0, 32'h0);
        issue(6'h36, 32'h0000_0063, 32'h0, 16'h0, 32'hCAFE_F00D);
        issue(6'h32, 32'h0000_0061, 32'h0, 16'h0, 32'h0);
        idle(2);
        // R2 immediate forms, including negative immediates
        issue(6'h3E, 32'h0000_0080, 32'h0, 16'hFFF0, 32'h0BAD_F00D);
        issue(6'h3A, 32'h0000_0090, 32'h0, 16'hFFE2, 32'h0);
        issue(6'h3C, 32'h0000_0030, 32'h0, 16'h0005, 32'h0000_007E);
        issue(6'h38, 32'h0000_0030, 32'h0, 16'h0005, 32'h0);
        issue(6'h3D, 32'h0000_00A0, 32'h0, 16'hFFFE, 32'h0000_BEAD);
        issue(6'h39, 32'h0000_00A0, 32'h0, 16'hFFFF, 32'h0);
        issue(6'h39, 32'h0000_0004, 32'h0, 16'h0000, 32'h0);
        idle(2);
        // R1 codes that are not memory accesses are ignored
        issue(6'h33, 32'h0000_0010, 32'h0, 16'h0, 32'hFFFF_FFFF);
        issue(6'h37, 32'h0000_0010, 32'h0, 16'h0, 32'hFFFF_FFFF);
        issue(6'h3F, 32'h0000_0010, 32'h0, 16'h0, 32'hFFFF_FFFF);
        issue(6'h20, 32'h0000_0010, 32'h0, 16'h0, 32'hFFFF_FFFF);
        issue(6'h12, 32'h0000_0010, 32'h0, 16'h0, 32'hFFFF_FFFF);
        issue(6'h32, 32'h0000_0010, 32'h0, 16'h0, 32'h0);
        idle(4);
        chk(due_q.size() == 0, "R7 all loads completed", 32'(due_q.size()), 32'h0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        chk(1'b0, "watchdog expired", 32'(cyc), 32'h0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule